// File: doc/BRIEF.md
# Board-ID Packet Sorter

This block sits in the packet pipeline of one board in a multi-board sparse matrix engine. Each work packet carries two addresses, a source and a destination. The upper bits of each address name the board that owns the memory word, and the lower bits give the word offset. For packets produced on this board, the sorter stamps a one-bit target selector taken from a build-time stage parameter: 0 means the source address is the one to service next (before the source read), and 1 means the destination address is (after the multiply). It then compares the board field of the selected address with the board's fixed identifier. A match sends the packet to the local output, which feeds the board's own memory queue. A mismatch sends it to the forward output, tagged with the board that must receive it. Every packet passes through the sorter, even when no forwarding is needed, so that both operation kinds share one path.

The sorter also watches the shared inter-board bus. A bus packet arrives together with the board it is meant for. The sorter takes it only when that board is this one, and otherwise consumes and drops it at once. An accepted bus packet goes to the local output. Its own selector bit decides which of its two addresses gives the offset to service. When a bus packet and a local packet both want the local output in the same cycle, the bus packet wins.

Each output is a one-entry register slot built as a small state machine. The slot has two states: EMPTY and FULL. It moves EMPTY to FULL on a push, FULL to EMPTY on a pop with no push, and stays FULL on a pop with a push in the same cycle. Data appears at an output one cycle after it is accepted.

Top module: `board_pkt_sorter`

## Requirements
- R1: After reset, both `loc_valid` and `fwd_valid` are 0, and `in_ready` is 1.
- R2: A packet accepted on the input whose target board field equals LOCAL_ID appears on the local output in the next cycle. Its addresses and data are unchanged, `loc_hdr` equals STAGE_SEL, and `fwd_valid` stays 0.
- R3: A packet accepted on the input whose target board field differs from LOCAL_ID appears on the forward output in the next cycle. `fwd_board` holds that target board, `fwd_hdr` equals STAGE_SEL, the fields are unchanged, and nothing reaches the local output.
- R4: The target field of an input packet is set by STAGE_SEL. With 0, the source address is the target; with 1, the destination address is. The board field of the other address has no effect on the routing.
- R5: A bus packet with `bus_board` equal to LOCAL_ID is accepted and appears on the local output in the next cycle, keeping its own `bus_hdr`. `loc_svc_offs` is the offset of the source address when `bus_hdr` is 0 and of the destination address when `bus_hdr` is 1.
- R6: A bus packet with `bus_board` different from LOCAL_ID is accepted at once (`bus_ready` is 1) and never reaches the local output.
- R7: When a bus packet for this board and a local-bound input packet are offered in the same cycle, the bus packet is taken and `in_ready` is 0. The input packet is taken in a later cycle.
- R8: An output whose valid is 1 while its ready is 0 keeps valid high and its fields stable. While the local slot is full and stalled, `in_ready` is 0 for local-bound packets and `bus_ready` is 0 for matching bus packets, so that no packet is lost.
- R9: For input packets, `loc_svc_offs` is the offset bits (the low OFFS_W bits) of the target address.
- R10: A stalled local output does not block remote-bound input packets, and a stalled forward output does not block local ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Input packet taken this cycle when valid |
| in_src_addr | input | BOARD_W+OFFS_W | Source address, board field in the upper bits |
| in_dst_addr | input | BOARD_W+OFFS_W | Destination address, board field in the upper bits |
| in_data | input | DATA_W | Packet operand |
| bus_valid | input | 1 | Broadcast packet present on the shared bus |
| bus_ready | output | 1 | Broadcast packet consumed this cycle |
| bus_board | input | BOARD_W | Board the broadcast packet is meant for |
| bus_hdr | input | 1 | Target selector of the broadcast packet (0 source, 1 destination) |
| bus_src_addr | input | BOARD_W+OFFS_W | Broadcast source address |
| bus_dst_addr | input | BOARD_W+OFFS_W | Broadcast destination address |
| bus_data | input | DATA_W | Broadcast operand |
| loc_valid | output | 1 | Local output valid |
| loc_ready | input | 1 | Local queue accepts |
| loc_hdr | output | 1 | Target selector of the local packet |
| loc_src_addr | output | BOARD_W+OFFS_W | Local packet source address |
| loc_dst_addr | output | BOARD_W+OFFS_W | Local packet destination address |
| loc_data | output | DATA_W | Local packet operand |
| loc_svc_offs | output | OFFS_W | Offset of the address to service locally |
| fwd_valid | output | 1 | Forward output valid |
| fwd_ready | input | 1 | Forward queue accepts |
| fwd_board | output | BOARD_W | Board the packet must travel to |
| fwd_hdr | output | 1 | Target selector of the forwarded packet |
| fwd_src_addr | output | BOARD_W+OFFS_W | Forwarded source address |
| fwd_dst_addr | output | BOARD_W+OFFS_W | Forwarded destination address |
| fwd_data | output | DATA_W | Forwarded operand |

## Verification
The bench builds two copies with 2-bit board fields, 8-bit offsets and 16-bit data. One copy uses LOCAL_ID 1 and STAGE_SEL 0, and the other uses LOCAL_ID 2 and STAGE_SEL 1, so both choices of target field are covered. In each copy, the board field of the address that is not the target is set to the local ID, which shows that it has no effect. The first copy also gets bus traffic with both selector values and with matching and foreign board IDs. It is driven into a same-cycle clash between bus and input and held stalled on the local output, which brings the priority rule and the lossless back-pressure within reach.

// File: rtl/bsorter_pkg.sv
package bsorter_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_t;

    typedef enum logic {
        TGT_SRC = 1'b0,
        TGT_DST = 1'b1
    } tgt_sel_t;
endpackage

// File: rtl/bsorter_pick.sv
module bsorter_pick
    import bsorter_pkg::*;
#(
    parameter int BOARD_W  = 2,
    parameter int OFFS_W   = 8,
    parameter int LOCAL_ID = 1,
    localparam int ADDR_W  = BOARD_W + OFFS_W
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    output logic [BOARD_W-1:0] tgt_board,
    output logic [OFFS_W-1:0]  tgt_offs,
    output logic              is_local
);
    localparam logic [BOARD_W-1:0] MY_ID = BOARD_W'(LOCAL_ID);

    logic [ADDR_W-1:0] tgt_addr;

    always_comb begin
        unique case (tgt_sel_t'(sel))
            TGT_SRC: tgt_addr = src_addr;
            TGT_DST: tgt_addr = dst_addr;
            default: tgt_addr = src_addr;
        endcase
        tgt_board = tgt_addr[ADDR_W-1 -: BOARD_W];
        tgt_offs  = tgt_addr[OFFS_W-1:0];
        is_local  = (tgt_board == MY_ID);
    end
endmodule

// File: rtl/bsorter_slot.sv
module bsorter_slot
    import bsorter_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_valid,
    output logic         push_ready,
    input  logic [W-1:0] push_data,
    output logic         pop_valid,
    input  logic         pop_ready,
    output logic [W-1:0] pop_data
);
    slot_state_t state_q, state_d;
    logic [W-1:0] data_q;
    logic         push;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            data_q <= push_data;
        end
    end

    always_comb begin
        push    = push_valid && push_ready;
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (push) state_d = SLOT_FULL;
            SLOT_FULL:  if (pop_ready && !push) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SLOT_EMPTY: begin
                pop_valid  = 1'b0;
                push_ready = 1'b1;
            end
            SLOT_FULL: begin
                pop_valid  = 1'b1;
                push_ready = pop_ready;
            end
            default: begin
                pop_valid  = 1'b0;
                push_ready = 1'b0;
            end
        endcase
        pop_data = data_q;
    end
endmodule

// File: rtl/board_pkt_sorter.sv
module board_pkt_sorter
    import bsorter_pkg::*;
#(
    parameter int BOARD_W   = 2,
    parameter int OFFS_W    = 8,
    parameter int DATA_W    = 16,
    parameter int LOCAL_ID  = 1,
    parameter int STAGE_SEL = 0,
    localparam int ADDR_W   = BOARD_W + OFFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ADDR_W-1:0]  in_src_addr,
    input  logic [ADDR_W-1:0]  in_dst_addr,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               bus_valid,
    output logic               bus_ready,
    input  logic [BOARD_W-1:0] bus_board,
    input  logic               bus_hdr,
    input  logic [ADDR_W-1:0]  bus_src_addr,
    input  logic [ADDR_W-1:0]  bus_dst_addr,
    input  logic [DATA_W-1:0]  bus_data,
    output logic               loc_valid,
    input  logic               loc_ready,
    output logic               loc_hdr,
    output logic [ADDR_W-1:0]  loc_src_addr,
    output logic [ADDR_W-1:0]  loc_dst_addr,
    output logic [DATA_W-1:0]  loc_data,
    output logic [OFFS_W-1:0]  loc_svc_offs,
    output logic               fwd_valid,
    input  logic               fwd_ready,
    output logic [BOARD_W-1:0] fwd_board,
    output logic               fwd_hdr,
    output logic [ADDR_W-1:0]  fwd_src_addr,
    output logic [ADDR_W-1:0]  fwd_dst_addr,
    output logic [DATA_W-1:0]  fwd_data
);
    localparam int LPKT_W = 1 + 2 * ADDR_W + DATA_W + OFFS_W;
    localparam int FPKT_W = BOARD_W + 1 + 2 * ADDR_W + DATA_W;
    localparam logic [BOARD_W-1:0] MY_ID = BOARD_W'(LOCAL_ID);
    localparam logic STAGE_BIT = (STAGE_SEL != 0);

    logic [BOARD_W-1:0] in_tgt_board;
    logic [OFFS_W-1:0]  in_tgt_offs;
    logic               in_local;
    logic [OFFS_W-1:0]  bus_offs;
    logic               bus_for_me;
    logic               bus_hit;
    logic               loc_space, fwd_space;
    logic               loc_push, fwd_push;
    logic [LPKT_W-1:0]  loc_wdata, loc_rdata;
    logic [FPKT_W-1:0]  fwd_wdata, fwd_rdata;

    bsorter_pick #(
        .BOARD_W (BOARD_W),
        .OFFS_W  (OFFS_W),
        .LOCAL_ID(LOCAL_ID)
    ) u_pick (
        .sel      (STAGE_BIT),
        .src_addr (in_src_addr),
        .dst_addr (in_dst_addr),
        .tgt_board(in_tgt_board),
        .tgt_offs (in_tgt_offs),
        .is_local (in_local)
    );

    // Bus packets choose their serviced field from their own header bit.
    always_comb begin
        unique case (tgt_sel_t'(bus_hdr))
            TGT_SRC: bus_offs = bus_src_addr[OFFS_W-1:0];
            TGT_DST: bus_offs = bus_dst_addr[OFFS_W-1:0];
            default: bus_offs = bus_src_addr[OFFS_W-1:0];
        endcase
    end

    // Arbitration: a matching bus packet has first claim on the local slot.
    always_comb begin
        bus_for_me = (bus_board == MY_ID);
        bus_hit    = bus_valid && bus_for_me;
        loc_push   = bus_hit ? loc_space : (in_valid && in_local && loc_space);
        fwd_push   = in_valid && !in_local && fwd_space;
        bus_ready  = !bus_for_me || loc_space;
        in_ready   = in_local ? (loc_space && !bus_hit) : fwd_space;
        if (bus_hit) begin
            loc_wdata = {bus_hdr, bus_src_addr, bus_dst_addr, bus_data, bus_offs};
        end else begin
            loc_wdata = {STAGE_BIT, in_src_addr, in_dst_addr, in_data, in_tgt_offs};
        end
        fwd_wdata = {in_tgt_board, STAGE_BIT, in_src_addr, in_dst_addr, in_data};
    end

    bsorter_slot #(.W(LPKT_W)) u_loc_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_valid(loc_push),
        .push_ready(loc_space),
        .push_data (loc_wdata),
        .pop_valid (loc_valid),
        .pop_ready (loc_ready),
        .pop_data  (loc_rdata)
    );

    bsorter_slot #(.W(FPKT_W)) u_fwd_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_valid(fwd_push),
        .push_ready(fwd_space),
        .push_data (fwd_wdata),
        .pop_valid (fwd_valid),
        .pop_ready (fwd_ready),
        .pop_data  (fwd_rdata)
    );

    assign {loc_hdr, loc_src_addr, loc_dst_addr, loc_data, loc_svc_offs} = loc_rdata;
    assign {fwd_board, fwd_hdr, fwd_src_addr, fwd_dst_addr, fwd_data}     = fwd_rdata;
endmodule

// File: rtl/bsorter_chk.sv
module bsorter_chk #(
    parameter int BOARD_W   = 2,
    parameter int OFFS_W    = 8,
    parameter int DATA_W    = 16,
    parameter int LOCAL_ID  = 1,
    parameter int STAGE_SEL = 0,
    localparam int ADDR_W   = BOARD_W + OFFS_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [ADDR_W-1:0]  in_src_addr,
    input logic [ADDR_W-1:0]  in_dst_addr,
    input logic [DATA_W-1:0]  in_data,
    input logic               bus_valid,
    input logic               bus_ready,
    input logic [BOARD_W-1:0] bus_board,
    input logic               loc_valid,
    input logic               loc_ready,
    input logic               loc_hdr,
    input logic [DATA_W-1:0]  loc_data,
    input logic               fwd_valid,
    input logic               fwd_ready,
    input logic [BOARD_W-1:0] fwd_board,
    input logic [DATA_W-1:0]  fwd_data
);
    localparam logic [BOARD_W-1:0] MY_ID = BOARD_W'(LOCAL_ID);

    logic [ADDR_W-1:0] tgt;
    logic              tgt_local;
    logic              bus_match;

    assign tgt       = (STAGE_SEL != 0) ? in_dst_addr : in_src_addr;
    assign tgt_local = (tgt[ADDR_W-1 -: BOARD_W] == MY_ID);
    assign bus_match = bus_valid && (bus_board == MY_ID);

    a_r2_local_next: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && tgt_local) |=> (loc_valid && loc_data == $past(in_data)));

    a_r3_fwd_not_me: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (fwd_board != MY_ID));

    a_r6_foreign_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_board != MY_ID) |-> bus_ready);

    a_r7_bus_first: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_match && in_valid && tgt_local) |-> !in_ready);

    a_r8_loc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && !loc_ready) |=> (loc_valid && $stable(loc_data) && $stable(loc_hdr)));

    a_r8_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_data) && $stable(fwd_board)));
endmodule

bind board_pkt_sorter bsorter_chk #(
    .BOARD_W  (BOARD_W),
    .OFFS_W   (OFFS_W),
    .DATA_W   (DATA_W),
    .LOCAL_ID (LOCAL_ID),
    .STAGE_SEL(STAGE_SEL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_src_addr(in_src_addr),
    .in_dst_addr(in_dst_addr),
    .in_data    (in_data),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_board  (bus_board),
    .loc_valid  (loc_valid),
    .loc_ready  (loc_ready),
    .loc_hdr    (loc_hdr),
    .loc_data   (loc_data),
    .fwd_valid  (fwd_valid),
    .fwd_ready  (fwd_ready),
    .fwd_board  (fwd_board),
    .fwd_data   (fwd_data)
);

// File: tb/sim_board_pkt_sorter.sv
`timescale 1ns/1ps
module sim_board_pkt_sorter;
    localparam int BW = 2;
    localparam int OW = 8;
    localparam int DW = 16;
    localparam int AW = BW + OW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          in_valid = 0, in1_valid = 0;
    logic [AW-1:0] in_src = '0, in_dst = '0;
    logic [DW-1:0] in_data = '0;
    logic          bus_valid = 0, bus_hdr = 0;
    logic [BW-1:0] bus_board = '0;
    logic [AW-1:0] bus_src = '0, bus_dst = '0;
    logic [DW-1:0] bus_data = '0;
    logic          loc_ready = 1, fwd_ready = 1;

    logic          in_ready, bus_ready, loc_valid, loc_hdr, fwd_valid, fwd_hdr;
    logic [AW-1:0] loc_src, loc_dst, fwd_src, fwd_dst;
    logic [DW-1:0] loc_data, fwd_data;
    logic [OW-1:0] loc_offs;
    logic [BW-1:0] fwd_board;

    logic          u1_in_ready, u1_bus_ready, u1_loc_valid, u1_loc_hdr, u1_fwd_valid, u1_fwd_hdr;
    logic [AW-1:0] u1_loc_src, u1_loc_dst, u1_fwd_src, u1_fwd_dst;
    logic [DW-1:0] u1_loc_data, u1_fwd_data;
    logic [OW-1:0] u1_loc_offs;
    logic [BW-1:0] u1_fwd_board;

    board_pkt_sorter #(.BOARD_W(BW), .OFFS_W(OW), .DATA_W(DW), .LOCAL_ID(1), .STAGE_SEL(0)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_src_addr(in_src), .in_dst_addr(in_dst),
        .in_data(in_data),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_board(bus_board), .bus_hdr(bus_hdr),
        .bus_src_addr(bus_src), .bus_dst_addr(bus_dst), .bus_data(bus_data),
        .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_hdr(loc_hdr), .loc_src_addr(loc_src),
        .loc_dst_addr(loc_dst), .loc_data(loc_data), .loc_svc_offs(loc_offs),
        .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_board(fwd_board), .fwd_hdr(fwd_hdr),
        .fwd_src_addr(fwd_src), .fwd_dst_addr(fwd_dst), .fwd_data(fwd_data)
    );

    board_pkt_sorter #(.BOARD_W(BW), .OFFS_W(OW), .DATA_W(DW), .LOCAL_ID(2), .STAGE_SEL(1)) u1 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in1_valid), .in_ready(u1_in_ready), .in_src_addr(in_src), .in_dst_addr(in_dst),
        .in_data(in_data),
        .bus_valid(1'b0), .bus_ready(u1_bus_ready), .bus_board(bus_board), .bus_hdr(bus_hdr),
        .bus_src_addr(bus_src), .bus_dst_addr(bus_dst), .bus_data(bus_data),
        .loc_valid(u1_loc_valid), .loc_ready(1'b1), .loc_hdr(u1_loc_hdr), .loc_src_addr(u1_loc_src),
        .loc_dst_addr(u1_loc_dst), .loc_data(u1_loc_data), .loc_svc_offs(u1_loc_offs),
        .fwd_valid(u1_fwd_valid), .fwd_ready(1'b1), .fwd_board(u1_fwd_board), .fwd_hdr(u1_fwd_hdr),
        .fwd_src_addr(u1_fwd_src), .fwd_dst_addr(u1_fwd_dst), .fwd_data(u1_fwd_data)
    );

    int n_checks = 0;
    int n_errs = 0;
    bit done = 0;

    function automatic logic [AW-1:0] mk(input int b, input int o);
        return {BW'(b), OW'(o)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        eq("R1 loc_valid after reset", 32'(loc_valid), 0);
        eq("R1 fwd_valid after reset", 32'(fwd_valid), 0);
        eq("R1 in_ready after reset", 32'(in_ready), 1);
    endtask

    task automatic t_local();
        in_valid = 1; in_src = mk(1, 'h34); in_dst = mk(3, 'h56); in_data = 16'hA001;
        @(negedge clk);
        in_valid = 0;
        eq("R2 loc_valid", 32'(loc_valid), 1);
        eq("R2 loc_data", 32'(loc_data), 32'hA001);
        eq("R2 loc_hdr", 32'(loc_hdr), 0);
        eq("R2 loc_dst", 32'(loc_dst), 32'(mk(3, 'h56)));
        eq("R9 loc_svc_offs", 32'(loc_offs), 32'h34);
        eq("R2 fwd idle", 32'(fwd_valid), 0);
        @(negedge clk);
        eq("R2 loc popped", 32'(loc_valid), 0);
    endtask

    task automatic t_remote();
        in_valid = 1; in_src = mk(0, 'h11); in_dst = mk(1, 'h22); in_data = 16'hB002;
        @(negedge clk);
        in_valid = 0;
        eq("R3 fwd_valid", 32'(fwd_valid), 1);
        eq("R3 fwd_board", 32'(fwd_board), 0);
        eq("R3 fwd_hdr", 32'(fwd_hdr), 0);
        eq("R3 fwd_data", 32'(fwd_data), 32'hB002);
        eq("R4 dst board ignored, loc idle", 32'(loc_valid), 0);
        @(negedge clk);
    endtask

    task automatic t_stage1();
        in1_valid = 1; in_src = mk(2, 'h22); in_dst = mk(0, 'h77); in_data = 16'hD004;
        @(negedge clk);
        eq("R4 stage1 forwards on dst board", 32'(u1_fwd_valid), 1);
        eq("R4 stage1 fwd_board", 32'(u1_fwd_board), 0);
        eq("R4 stage1 fwd_hdr", 32'(u1_fwd_hdr), 1);
        eq("R4 stage1 src board ignored", 32'(u1_loc_valid), 0);
        in_src = mk(0, 'h05); in_dst = mk(2, 'h99); in_data = 16'hD005;
        @(negedge clk);
        in1_valid = 0;
        eq("R4 stage1 local", 32'(u1_loc_valid), 1);
        eq("R4 stage1 loc_hdr", 32'(u1_loc_hdr), 1);
        eq("R9 stage1 svc offs", 32'(u1_loc_offs), 32'h99);
        @(negedge clk);
    endtask

    task automatic t_bus_hit();
        bus_valid = 1; bus_board = 1; bus_hdr = 1;
        bus_src = mk(3, 'h10); bus_dst = mk(1, 'h20); bus_data = 16'hC003;
        @(negedge clk);
        eq("R5 bus to loc", 32'(loc_valid), 1);
        eq("R5 bus data", 32'(loc_data), 32'hC003);
        eq("R5 bus hdr kept", 32'(loc_hdr), 1);
        eq("R5 hdr1 svc offs", 32'(loc_offs), 32'h20);
        bus_hdr = 0; bus_data = 16'hC013;
        @(negedge clk);
        bus_valid = 0;
        eq("R5 hdr0 data", 32'(loc_data), 32'hC013);
        eq("R5 hdr0 svc offs", 32'(loc_offs), 32'h10);
        @(negedge clk);
    endtask

    task automatic t_bus_miss();
        bus_valid = 1; bus_board = 2; bus_hdr = 0; bus_data = 16'hE006;
        #1;
        eq("R6 foreign bus_ready", 32'(bus_ready), 1);
        @(negedge clk);
        bus_valid = 0;
        eq("R6 foreign dropped", 32'(loc_valid), 0);
    endtask

    task automatic t_bus_wins();
        in_valid = 1; in_src = mk(1, 'h01); in_dst = mk(0, 'h02); in_data = 16'h1111;
        bus_valid = 1; bus_board = 1; bus_hdr = 0; bus_src = mk(1, 'h03); bus_data = 16'h2222;
        #1;
        eq("R7 in_ready low on clash", 32'(in_ready), 0);
        eq("R7 bus_ready high on clash", 32'(bus_ready), 1);
        @(negedge clk);
        bus_valid = 0;
        eq("R7 bus packet first", 32'(loc_data), 32'h2222);
        #1;
        eq("R7 input taken later", 32'(in_ready), 1);
        @(negedge clk);
        in_valid = 0;
        eq("R7 input packet next", 32'(loc_data), 32'h1111);
        @(negedge clk);
    endtask

    task automatic t_backpressure();
        loc_ready = 0;
        in_valid = 1; in_src = mk(1, 'h40); in_dst = mk(2, 'h41); in_data = 16'hAAAA;
        @(negedge clk);
        in_data = 16'hBBBB; in_src = mk(1, 'h42);
        bus_valid = 1; bus_board = 1; bus_data = 16'hCCCC;
        #1;
        eq("R8 in_ready low when loc stalled", 32'(in_ready), 0);
        eq("R8 bus_ready low when loc stalled", 32'(bus_ready), 0);
        repeat (3) @(negedge clk);
        bus_valid = 0;
        eq("R8 loc held valid", 32'(loc_valid), 1);
        eq("R8 loc held data", 32'(loc_data), 32'hAAAA);
        in_src = mk(3, 'h50); in_data = 16'hDDDD;
        #1;
        eq("R10 remote passes stalled loc", 32'(in_ready), 1);
        @(negedge clk);
        in_valid = 0;
        eq("R10 fwd delivered", 32'(fwd_data), 32'hDDDD);
        eq("R10 fwd_board", 32'(fwd_board), 3);
        eq("R8 loc still held", 32'(loc_data), 32'hAAAA);
        loc_ready = 1;
        @(negedge clk);
        eq("R8 loc drained", 32'(loc_valid), 0);
        in_valid = 1; in_src = mk(1, 'h42); in_data = 16'hBBBB;
        @(negedge clk);
        in_valid = 0;
        eq("R8 later packet delivered", 32'(loc_data), 32'hBBBB);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_local();
        t_remote();
        t_stage1();
        t_bus_hit();
        t_bus_miss();
        t_bus_wins();
        t_backpressure();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule